// File: doc/BRIEF.md
# Parallel-Port Forward Command/Data Transmitter

This block is the host-side sender of an enhanced parallel port working in the forward direction. Software fills two independent byte queues. One queue takes command bytes and the other takes ordinary data bytes. The block moves one byte at a time onto an 8-bit bus. A qualifier line tells the peripheral what kind of byte is on the bus: it is low for a command and high for data. Each byte is then passed across with a strobe/busy handshake.

A command byte reaches the bus unchanged. Its top bit tells the peripheral how to read the rest of the byte. With bit 7 clear, bits 6:0 are a repeat count from 0 to 127 for the data byte that follows. With bit 7 set, bits 6:0 are a channel number from 0 to 127. To send compressed data, software pushes the count into the command queue and the byte to be repeated into the data queue. The sender always serves the command queue first, so the count goes out ahead of its byte.

A queue write never waits on the handshake: it is either stored at once or refused at once. A refused write sets a sticky overflow flag.

Top module: `pport_fwd_tx`

## Requirements
- R1: After reset, strobe_n is 1, host_ack is 1, both queues are empty (empty flags 1, full flags 0) and both overflow flags are 0.
- R2: A byte from the command queue is presented with host_ack = 0 and a byte from the data queue with host_ack = 1; the 8 bits reach pd_out unchanged, so bit 7 = 0 (run-length count) and bit 7 = 1 (channel address) both pass as written.
- R3: Whenever the command queue holds an entry at the moment a new byte is chosen, that entry is sent before any data-queue entry.
- R4: strobe_n is driven low only after pd_out and host_ack hold the new byte. It stays low until periph_busy is seen high and is then released. It is not driven low again until periph_busy has been seen low.
- R5: pd_out and host_ack do not change while strobe_n is low.
- R6: Each queue delivers its bytes in the order they were written, including for writes on back-to-back cycles.
- R7: A queue reports full after 16 unsent entries. A write to a full queue is dropped and sets that queue's overflow flag, which stays set until reset. The other queue is not affected.
- R8: A write to a queue that is not full is stored on the clock edge where it is presented, even while a handshake is stalled; the empty flag clears on the next cycle.
- R9: When a count and its data byte are written in the same cycle, the count goes out first, followed by the data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_wr | input | 1 | Write strobe for the command queue |
| cmd_wdata | input | 8 | Command byte (bit 7: 0 = count, 1 = channel) |
| cmd_full | output | 1 | Command queue holds 16 entries |
| cmd_empty | output | 1 | Command queue holds no entry |
| cmd_ovf | output | 1 | Sticky: a command write was dropped |
| dat_wr | input | 1 | Write strobe for the data queue |
| dat_wdata | input | 8 | Data byte |
| dat_full | output | 1 | Data queue holds 16 entries |
| dat_empty | output | 1 | Data queue holds no entry |
| dat_ovf | output | 1 | Sticky: a data write was dropped |
| periph_busy | input | 1 | Peripheral busy, asynchronous to clk |
| pd_out | output | 8 | Byte on the parallel bus |
| host_ack | output | 1 | Byte qualifier: 0 = command, 1 = data |
| strobe_n | output | 1 | Active-low byte strobe |

## Verification
Two functions can fall on the same cycle: the selection of the next byte from the two queues, and the arrival of new writes. The bench holds the peripheral's busy reply so that one byte stays in flight. It then writes data, a command and more data while that byte is stalled, and also writes a count and its data byte on a single cycle. The order of the bytes the peripheral model captures, each with its qualifier, is compared with the order required by command priority. A queue is also filled to capacity during a stall, so that a refused write and the later draining can be checked against the dropped byte and the sticky flag.

// File: rtl/pport_fwd_pkg.sv
package pport_fwd_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_STRB  = 2'd2,
    ST_RELS  = 2'd3
  } tx_state_e;

  typedef struct packed {
    logic              is_data;
    logic [BYTE_W-1:0] value;
  } bus_word_t;
endpackage

// File: rtl/pport_rst_sync.sv
module pport_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pport_bit_sync.sv
module pport_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_nx;

  always_comb sh_nx = {sh_q[STAGES-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_nx;
  end

  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/pport_byte_queue.sv
module pport_byte_queue #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty,
  output logic             ovf
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wp_q, wp_nx, rp_q, rp_nx;
  logic             ovf_q, ovf_nx;
  logic             accept, take;

  always_comb begin
    empty  = (wp_q == rp_q);
    full   = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
    accept = wr & ~full;
    take   = pop & ~empty;
    wp_nx  = wp_q + {{AW{1'b0}}, accept};
    rp_nx  = rp_q + {{AW{1'b0}}, take};
    ovf_nx = ovf_q | (wr & full);
    rdata  = mem[rp_q[AW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_nx;
      rp_q  <= rp_nx;
      ovf_q <= ovf_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wp_q[AW-1:0]] <= wdata;
  end

  assign ovf = ovf_q;

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R6
  AST_FULL_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && full && !pop) |=> (full && ovf)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R7
  AST_WRITE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !full && !pop) |=> !empty); // R8
endmodule

// File: rtl/pport_fwd_seq.sv
module pport_fwd_seq
  import pport_fwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_empty,
  input  logic [BYTE_W-1:0] cmd_rdata,
  input  logic              dat_empty,
  input  logic [BYTE_W-1:0] dat_rdata,
  input  logic              busy_s,
  output logic              cmd_pop,
  output logic              dat_pop,
  output logic [BYTE_W-1:0] pd_out,
  output logic              host_ack,
  output logic              strobe_n
);
  tx_state_e st_q, st_nx;
  bus_word_t word_q, word_nx;
  logic      load_en;
  logic      strb_q, strb_nx;

  always_comb begin
    st_nx   = st_q;
    word_nx = word_q;
    load_en = 1'b0;
    strb_nx = strb_q;
    cmd_pop = 1'b0;
    dat_pop = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!busy_s) begin
          if (!cmd_empty) begin
            cmd_pop = 1'b1;
            load_en = 1'b1;
            word_nx = '{is_data: 1'b0, value: cmd_rdata};
            st_nx   = ST_SETUP;
          end else if (!dat_empty) begin
            dat_pop = 1'b1;
            load_en = 1'b1;
            word_nx = '{is_data: 1'b1, value: dat_rdata};
            st_nx   = ST_SETUP;
          end
        end
      end
      ST_SETUP: begin
        strb_nx = 1'b0;
        st_nx   = ST_STRB;
      end
      ST_STRB: begin
        if (busy_s) begin
          strb_nx = 1'b1;
          st_nx   = ST_RELS;
        end
      end
      ST_RELS: begin
        if (!busy_s) st_nx = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      strb_q <= 1'b1;
      word_q <= '{is_data: 1'b1, value: '0};
    end else begin
      st_q   <= st_nx;
      strb_q <= strb_nx;
      if (load_en) word_q <= word_nx;
    end
  end

  assign pd_out   = word_q.value;
  assign host_ack = word_q.is_data;
  assign strobe_n = strb_q;

  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && !busy_s) |=> !strobe_n); // R4
  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |-> ($stable(pd_out) && $stable(host_ack))); // R5
  AST_NO_RESTRIKE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_n && busy_s) |=> strobe_n); // R4
endmodule

// File: rtl/pport_fwd_tx.sv
module pport_fwd_tx
  import pport_fwd_pkg::*;
#(
  parameter int unsigned Q_DEPTH     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [BYTE_W-1:0] cmd_wdata,
  output logic              cmd_full,
  output logic              cmd_empty,
  output logic              cmd_ovf,
  input  logic              dat_wr,
  input  logic [BYTE_W-1:0] dat_wdata,
  output logic              dat_full,
  output logic              dat_empty,
  output logic              dat_ovf,
  input  logic              periph_busy,
  output logic [BYTE_W-1:0] pd_out,
  output logic              host_ack,
  output logic              strobe_n
);
  localparam int unsigned NQ    = 2;
  localparam int unsigned Q_CMD = 0;
  localparam int unsigned Q_DAT = 1;

  logic              rst_i_n;
  logic              busy_s;
  logic [NQ-1:0]     q_wr, q_pop, q_full, q_empty, q_ovf;
  logic [BYTE_W-1:0] q_wdata [NQ];
  logic [BYTE_W-1:0] q_rdata [NQ];

  pport_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  pport_bit_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
    .clk(clk), .rst_n(rst_i_n), .din(periph_busy), .dout(busy_s)
  );

  assign q_wr[Q_CMD]    = cmd_wr;
  assign q_wr[Q_DAT]    = dat_wr;
  assign q_wdata[Q_CMD] = cmd_wdata;
  assign q_wdata[Q_DAT] = dat_wdata;

  for (genvar g = 0; g < NQ; g++) begin : g_queue
    pport_byte_queue #(.DEPTH(Q_DEPTH), .WIDTH(BYTE_W)) u_q (
      .clk  (clk),
      .rst_n(rst_i_n),
      .wr   (q_wr[g]),
      .wdata(q_wdata[g]),
      .pop  (q_pop[g]),
      .rdata(q_rdata[g]),
      .full (q_full[g]),
      .empty(q_empty[g]),
      .ovf  (q_ovf[g])
    );
  end

  pport_fwd_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .cmd_empty(q_empty[Q_CMD]),
    .cmd_rdata(q_rdata[Q_CMD]),
    .dat_empty(q_empty[Q_DAT]),
    .dat_rdata(q_rdata[Q_DAT]),
    .busy_s   (busy_s),
    .cmd_pop  (q_pop[Q_CMD]),
    .dat_pop  (q_pop[Q_DAT]),
    .pd_out   (pd_out),
    .host_ack (host_ack),
    .strobe_n (strobe_n)
  );

  assign cmd_full  = q_full[Q_CMD];
  assign cmd_empty = q_empty[Q_CMD];
  assign cmd_ovf   = q_ovf[Q_CMD];
  assign dat_full  = q_full[Q_DAT];
  assign dat_empty = q_empty[Q_DAT];
  assign dat_ovf   = q_ovf[Q_DAT];

  AST_CMD_FIRST: assert property (@(posedge clk) disable iff (!rst_i_n)
    q_pop[Q_DAT] |-> q_empty[Q_CMD]); // R3
  AST_CMD_TAG: assert property (@(posedge clk) disable iff (!rst_i_n)
    q_pop[Q_CMD] |=> !host_ack); // R2
  AST_DAT_TAG: assert property (@(posedge clk) disable iff (!rst_i_n)
    q_pop[Q_DAT] |=> host_ack); // R2
  AST_ONE_POP: assert property (@(posedge clk) disable iff (!rst_i_n)
    $countones(q_pop) <= 1); // R6
endmodule

// File: tb/pport_fwd_tx_bench.sv
`timescale 1ns/1ps
module pport_fwd_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_wr, dat_wr, periph_busy;
  logic [7:0] cmd_wdata, dat_wdata, pd_out;
  logic       cmd_full, cmd_empty, cmd_ovf, dat_full, dat_empty, dat_ovf;
  logic       host_ack, strobe_n;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  logic [7:0] cap_b [64];
  logic       cap_a [64];
  int         ncap = 0;
  bit         periph_en = 1;

  always #2 clk = ~clk;

  pport_fwd_tx u_pport_fwd_tx (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_full(cmd_full),
    .cmd_empty(cmd_empty), .cmd_ovf(cmd_ovf),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_full(dat_full),
    .dat_empty(dat_empty), .dat_ovf(dat_ovf),
    .periph_busy(periph_busy), .pd_out(pd_out),
    .host_ack(host_ack), .strobe_n(strobe_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  // Peripheral model: captures each strobed byte, checks R4/R5 on the way.
  initial begin
    periph_busy = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && !strobe_n && periph_en) begin
        logic [7:0] b;
        logic       a;
        b = pd_out;
        a = host_ack;
        if (ncap < 64) begin cap_b[ncap] = b; cap_a[ncap] = a; end
        ncap++;
        for (int i = 0; i < 3; i++) begin
          @(negedge clk);
          if (strobe_n !== 1'b0) chk(0, "R4", "strobe released before busy", strobe_n, 0);
          if (pd_out !== b || host_ack !== a) chk(0, "R5", "bus changed under strobe", pd_out, b);
        end
        periph_busy = 1'b1;
        for (int t = 0; t < 50 && strobe_n === 1'b0; t++) @(negedge clk);
        chk(strobe_n === 1'b1, "R4", "strobe released after busy", strobe_n, 1);
        for (int i = 0; i < 4; i++) begin
          @(negedge clk);
          if (strobe_n !== 1'b1) chk(0, "R4", "strobe re-asserted while busy", strobe_n, 1);
        end
        periph_busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    finish_run();
  end

  task automatic wr_cmd(input logic [7:0] b);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = b;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] b);
    @(negedge clk); dat_wr = 1'b1; dat_wdata = b;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic wait_caps(input int n);
    for (int t = 0; t < 4000 && ncap < n; t++) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic expect_cap(input int idx, input logic [7:0] b, input logic a,
                            input string req);
    chk(cap_b[idx] === b, req, "captured byte", cap_b[idx], b);
    chk(cap_a[idx] === a, req, "captured host_ack", cap_a[idx], a);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cmd_wr = 0; dat_wr = 0; cmd_wdata = 0; dat_wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(strobe_n === 1'b1, "R1", "strobe_n", strobe_n, 1);
    chk(host_ack === 1'b1, "R1", "host_ack", host_ack, 1);
    chk({cmd_empty, dat_empty} === 2'b11, "R1", "empty", {cmd_empty, dat_empty}, 3);
    chk({cmd_full, dat_full, cmd_ovf, dat_ovf} === 4'b0, "R1", "full/ovf",
        {cmd_full, dat_full, cmd_ovf, dat_ovf}, 0);
  endtask

  task automatic t_tags();
    int base = ncap;
    wr_dat(8'hA5); wait_caps(base + 1);
    wr_cmd(8'h85); wait_caps(base + 2);
    wr_cmd(8'h05); wait_caps(base + 3);
    chk(ncap == base + 3, "R2", "byte count", ncap - base, 3);
    expect_cap(base,     8'hA5, 1'b1, "R2");
    expect_cap(base + 1, 8'h85, 1'b0, "R2");
    expect_cap(base + 2, 8'h05, 1'b0, "R2");
  endtask

  task automatic t_priority();
    int base = ncap;
    periph_en = 0;
    wr_dat(8'hD0);
    repeat (6) @(negedge clk);
    wr_dat(8'h22);
    chk(dat_empty === 1'b0, "R8", "data stored during stall", dat_empty, 0);
    wr_cmd(8'h03);
    chk(cmd_empty === 1'b0, "R8", "command stored during stall", cmd_empty, 0);
    wr_dat(8'h44);
    periph_en = 1;
    wait_caps(base + 4);
    expect_cap(base,     8'hD0, 1'b1, "R3");
    expect_cap(base + 1, 8'h03, 1'b0, "R3");
    expect_cap(base + 2, 8'h22, 1'b1, "R3");
    expect_cap(base + 3, 8'h44, 1'b1, "R3");
  endtask

  task automatic t_pair();
    int base = ncap;
    @(negedge clk);
    cmd_wr = 1; cmd_wdata = 8'h7F; dat_wr = 1; dat_wdata = 8'h55;
    @(negedge clk);
    cmd_wr = 0; dat_wr = 0;
    wait_caps(base + 2);
    expect_cap(base,     8'h7F, 1'b0, "R9");
    expect_cap(base + 1, 8'h55, 1'b1, "R9");
  endtask

  task automatic t_order();
    int base = ncap;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); dat_wr = 1; dat_wdata = 8'h30 + 8'(i);
    end
    @(negedge clk); dat_wr = 0;
    wait_caps(base + 5);
    for (int i = 0; i < 5; i++) expect_cap(base + i, 8'h30 + 8'(i), 1'b1, "R6");
  endtask

  task automatic t_overflow();
    int base = ncap;
    periph_en = 0;
    wr_cmd(8'hC0);
    repeat (6) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); cmd_wr = 1; cmd_wdata = 8'(i);
    end
    @(negedge clk); cmd_wr = 0;
    chk(cmd_full === 1'b1, "R7", "full at 16", cmd_full, 1);
    chk(cmd_ovf === 1'b0, "R7", "no overflow yet", cmd_ovf, 0);
    wr_cmd(8'h7E);
    chk(cmd_ovf === 1'b1, "R7", "overflow set", cmd_ovf, 1);
    chk({dat_ovf, dat_empty, dat_full} === 3'b010, "R7", "data queue untouched",
        {dat_ovf, dat_empty, dat_full}, 2);
    periph_en = 1;
    wait_caps(base + 17);
    repeat (60) @(negedge clk);
    chk(ncap == base + 17, "R7", "dropped byte not sent", ncap - base, 17);
    expect_cap(base, 8'hC0, 1'b0, "R7");
    for (int i = 0; i < 16; i++) expect_cap(base + 1 + i, 8'(i), 1'b0, "R7");
    chk(cmd_ovf === 1'b1, "R7", "overflow sticky", cmd_ovf, 1);
    chk(cmd_empty === 1'b1, "R7", "drained", cmd_empty, 1);
  endtask

  initial begin
    t_reset();
    t_tags();
    t_priority();
    t_pair();
    t_order();
    t_overflow();
    finish_run();
  end
endmodule